// File: doc/BRIEF.md
# Raw Sample Capture and Replay Buffer

This block is a circular store for one channel of oversampled converter data. It runs at four samples per bunch crossing. It has two modes. In monitoring mode every incoming 10-bit sample is written to the store, so the samples around a trigger accept are still there when the host fetches them. In replay mode the data path stops writing. Instead it reads samples that the host loaded earlier and drives them out in place of the live converter stream.

The data-path address is not a free-running pointer. It is formed from a crossing (tick) counter in the upper bits and a sample-within-tick (slot) counter in the lower 2 bits. Each stored word therefore lines up with the crossing that produced it. One turn is 159 ticks, which is 636 words of the 1024-word store. A separate host port reads and writes any word as 16 bits. A freeze input holds the monitored record still while the host drains it.

Top module: `raw_sample_capture`

## Requirements
- R1: After reset, `tick_no` is 0, `slot_no` is 0, `play_valid` is 0, `play_data` is 0 and `host_rdata` is 0.
- R2: Each cycle with `smp_valid` high advances `slot_no` by one. When `slot_no` steps from 3 to 0, `tick_no` advances by one.
- R3: `tick_no` counts 0 to 158. A strobe at tick 158, slot 3 returns both counters to 0.
- R4: In monitoring mode (`replay_en` low, `freeze` low), a strobe stores `smp_data` at word address `{tick_no, slot_no}`, where tick is bits 9:2 and slot is bits 1:0. A host read of that word returns the sample in bits 9:0 and zero in bits 15:10.
- R5: A host write stores all 16 bits of `host_wdata` at `host_addr`. The word at `host_addr` appears on `host_rdata` one clock after the address is presented. Any word from 0 to 1023 is reachable.
- R6: In replay mode, a strobe reads the word at `{tick_no, slot_no}`. One clock later `play_valid` is high for one cycle and `play_data` holds bits 9:0 of that word.
- R7: In replay mode the data path never writes, so data loaded by the host reads back unchanged after replay strobes.
- R8: While `freeze` is high, monitoring strobes store nothing, but the counters still advance.
- R9: When a monitoring write and a host write hit the same word in the same cycle, the host data is kept.
- R10: Without a strobe, the counters hold their values and nothing is written by the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| replay_en | input | 1 | 0 = monitoring, 1 = replay |
| freeze | input | 1 | Blocks monitoring writes |
| smp_valid | input | 1 | Sample strobe, four per tick |
| smp_data | input | 10 | Live converter sample |
| play_valid | output | 1 | Replayed sample is valid |
| play_data | output | 10 | Replayed sample |
| tick_no | output | 8 | Current tick counter |
| slot_no | output | 2 | Current sample slot within the tick |
| host_we | input | 1 | Host write enable |
| host_addr | input | 10 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one clock latency |

## Verification
The counters and any data-path write change on the rising edge that samples a strobe. A replayed sample and its valid flag appear one edge after the strobe. Host read data appears one edge after the address is presented. The bench drives every input on a falling edge and checks each output at the next falling edge, so exactly one rising edge has elapsed and the value is stable. Replay strobes are checked again one cycle later, to confirm that the valid flag has dropped.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   typedef enum logic {
      RSC_MONITOR = 1'b0,
      RSC_REPLAY  = 1'b1
   } rsc_mode_e;

   localparam int RSC_SAMPLE_W = 10;
   localparam int RSC_WORD_W   = 18;
   localparam int RSC_HOST_W   = 16;
   localparam int RSC_TICK_W   = 8;
   localparam int RSC_SLOT_W   = 2;
   localparam int RSC_TURN     = 159;
endpackage

// File: rtl/rsc_slot_counter.sv
module rsc_slot_counter #(
   parameter int TICK_W         = 8,
   parameter int SLOT_W         = 2,
   parameter int TICKS_PER_TURN = 159
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   output logic [TICK_W-1:0] tick_o,
   output logic [SLOT_W-1:0] slot_o
);
   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_TURN - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = '1;

   generate
      if (TICKS_PER_TURN < 1 || TICKS_PER_TURN > (1 << TICK_W)) begin : g_bad_turn
         $error("TICKS_PER_TURN does not fit in TICK_W bits");
      end
      if (SLOT_W < 1) begin : g_bad_slot
         $error("SLOT_W must be at least 1");
      end
   endgenerate

   logic [TICK_W-1:0] tick_q;
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
         slot_q <= '0;
      end else if (step) begin
         if (slot_q == SLOT_LAST) begin
            slot_q <= '0;
            tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
         end else begin
            slot_q <= slot_q + 1'b1;
         end
      end
   end

   assign tick_o = tick_q;
   assign slot_o = slot_q;

   // R2: every strobe moves the slot forward by one
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> slot_q == SLOT_W'($past(slot_q) + 1'b1));

   // R3: the last slot of the last tick returns to the start of the turn
   p_turn_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && slot_q == SLOT_LAST && tick_q == TICK_LAST) |=> (tick_q == '0 && slot_q == '0));

   // R3: the tick never leaves the turn
   p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q <= TICK_LAST);

   // R10: no strobe, no movement
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(tick_q) && $stable(slot_q)));
endmodule

// File: rtl/rsc_dual_ram.sv
module rsc_dual_ram #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 18,
   parameter int A_RD_W = 10,
   parameter int B_RD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [WORD_W-1:0] a_wdata,
   output logic [A_RD_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [WORD_W-1:0] b_wdata,
   output logic [B_RD_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (A_RD_W > WORD_W || B_RD_W > WORD_W) begin : g_bad_width
         $error("read widths exceed the stored word");
      end
   endgenerate

   logic [WORD_W-1:0] mem [DEPTH];

   // Port B is written after port A, so the host wins a same-word collision.
   always_ff @(posedge clk) begin
      if (a_en && a_we) mem[a_addr] <= a_wdata;
      if (b_we)         mem[b_addr] <= b_wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_en && !a_we) a_rdata <= mem[a_addr][A_RD_W-1:0];
         b_rdata <= mem[b_addr][B_RD_W-1:0];
      end
   end

   // R4: a data-path write without a host clash lands in the array
   p_a_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we && !(b_we && b_addr == a_addr)) |=> mem[$past(a_addr)] == $past(a_wdata));

   // R9: on a same-word clash the host data is the one kept
   p_clash_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we && b_we && b_addr == a_addr) |=> mem[$past(b_addr)] == $past(b_wdata));
endmodule

// File: rtl/rsc_play_stage.sv
module rsc_play_stage #(
   parameter int SAMPLE_W = 10,
   parameter int PIPE     = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_fire,
   input  logic [SAMPLE_W-1:0] rd_word,
   output logic                play_valid,
   output logic [SAMPLE_W-1:0] play_data
);
   logic fire_q;

   always_ff @(posedge clk) begin
      if (!rst_n) fire_q <= 1'b0;
      else        fire_q <= rd_fire;
   end

   generate
      if (PIPE < 0 || PIPE > 1) begin : g_bad_pipe
         $error("PIPE must be 0 or 1");
      end
      if (PIPE == 0) begin : g_direct
         assign play_valid = fire_q;
         assign play_data  = rd_word;
      end else begin : g_staged
         logic                valid_q;
         logic [SAMPLE_W-1:0] data_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q <= 1'b0;
               data_q  <= '0;
            end else begin
               valid_q <= fire_q;
               if (fire_q) data_q <= rd_word;
            end
         end
         assign play_valid = valid_q;
         assign play_data  = data_q;
      end
   endgenerate
endmodule

// File: rtl/raw_sample_capture.sv
module raw_sample_capture
   import rsc_pkg::*;
#(
   parameter int SAMPLE_W       = RSC_SAMPLE_W,
   parameter int WORD_W         = RSC_WORD_W,
   parameter int HOST_W         = RSC_HOST_W,
   parameter int TICK_W         = RSC_TICK_W,
   parameter int SLOT_W         = RSC_SLOT_W,
   parameter int TICKS_PER_TURN = RSC_TURN,
   parameter int PLAY_PIPE      = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     replay_en,
   input  logic                     freeze,
   input  logic                     smp_valid,
   input  logic [SAMPLE_W-1:0]      smp_data,
   output logic                     play_valid,
   output logic [SAMPLE_W-1:0]      play_data,
   output logic [TICK_W-1:0]        tick_no,
   output logic [SLOT_W-1:0]        slot_no,
   input  logic                     host_we,
   input  logic [TICK_W+SLOT_W-1:0] host_addr,
   input  logic [HOST_W-1:0]        host_wdata,
   output logic [HOST_W-1:0]        host_rdata
);
   localparam int ADDR_W = TICK_W + SLOT_W;

   generate
      if (SAMPLE_W > HOST_W || HOST_W > WORD_W) begin : g_bad_pack
         $error("need SAMPLE_W <= HOST_W <= WORD_W");
      end
   endgenerate

   rsc_mode_e         mode;
   logic              dp_wr;
   logic              dp_rd;
   logic [ADDR_W-1:0] dp_addr;
   logic [WORD_W-1:0] dp_word;
   logic [WORD_W-1:0] host_word;
   logic [SAMPLE_W-1:0] rd_sample;

   assign mode = replay_en ? RSC_REPLAY : RSC_MONITOR;

   rsc_slot_counter #(
      .TICK_W(TICK_W), .SLOT_W(SLOT_W), .TICKS_PER_TURN(TICKS_PER_TURN)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n), .step(smp_valid),
      .tick_o(tick_no), .slot_o(slot_no)
   );

   assign dp_addr   = {tick_no, slot_no};
   assign dp_wr     = smp_valid && (mode == RSC_MONITOR) && !freeze;
   assign dp_rd     = smp_valid && (mode == RSC_REPLAY);
   assign dp_word   = {{(WORD_W-SAMPLE_W){1'b0}}, smp_data};
   assign host_word = {{(WORD_W-HOST_W){1'b0}}, host_wdata};

   rsc_dual_ram #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .A_RD_W(SAMPLE_W), .B_RD_W(HOST_W)
   ) ram_i (
      .clk(clk), .rst_n(rst_n),
      .a_en(dp_wr || dp_rd), .a_we(dp_wr), .a_addr(dp_addr),
      .a_wdata(dp_word), .a_rdata(rd_sample),
      .b_we(host_we), .b_addr(host_addr), .b_wdata(host_word),
      .b_rdata(host_rdata)
   );

   rsc_play_stage #(
      .SAMPLE_W(SAMPLE_W), .PIPE(PLAY_PIPE)
   ) play_i (
      .clk(clk), .rst_n(rst_n), .rd_fire(dp_rd), .rd_word(rd_sample),
      .play_valid(play_valid), .play_data(play_data)
   );

   // R6: replayed output appears only after a replay strobe
   generate
      if (PLAY_PIPE == 0) begin : g_chk_play
         p_play_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
            play_valid |-> $past(smp_valid && replay_en));
      end
   endgenerate
endmodule

// File: tb/raw_sample_capture_tb_top.sv
module raw_sample_capture_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        replay_en = 1'b0;
   logic        freeze = 1'b0;
   logic        smp_valid = 1'b0;
   logic [9:0]  smp_data = '0;
   logic        play_valid;
   logic [9:0]  play_data;
   logic [7:0]  tick_no;
   logic [1:0]  slot_no;
   logic        host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   raw_sample_capture dut_i (
      .clk(clk), .rst_n(rst_n), .replay_en(replay_en), .freeze(freeze),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .play_valid(play_valid), .play_data(play_data),
      .tick_no(tick_no), .slot_no(slot_no),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   // {sample[9:0], expected word address[9:0] before the strobe}
   localparam logic [19:0] VEC [8] = '{
      {10'h3FF, 10'd0}, {10'h200, 10'd1}, {10'h001, 10'd2}, {10'h155, 10'd3},
      {10'h2AA, 10'd4}, {10'h0F0, 10'd5}, {10'h30C, 10'd6}, {10'h07E, 10'd7}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [9:0] s);
      @(negedge clk); smp_valid = 1'b1; smp_data = s;
      @(negedge clk); smp_valid = 1'b0;
   endtask

   task automatic host_write(input logic [9:0] a, input logic [15:0] d);
      @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk); host_we = 1'b0;
   endtask

   task automatic host_read(input logic [9:0] a, output logic [15:0] d);
      @(negedge clk); host_addr = a;
      @(negedge clk); d = host_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(tick_no == 8'd0, "R1 tick", int'(tick_no), 0);
      check(slot_no == 2'd0, "R1 slot", int'(slot_no), 0);
      check(play_valid == 1'b0, "R1 play_valid", int'(play_valid), 0);
      check(play_data == 10'd0 && host_rdata == 16'd0, "R1 data", int'(host_rdata), 0);
      rst_n = 1'b1;

      // R2, R4: walk the vector table in monitoring mode
      for (int i = 0; i < 8; i++) begin
         check({tick_no, slot_no} == VEC[i][9:0], "R2 counters before strobe",
               int'({tick_no, slot_no}), int'(VEC[i][9:0]));
         strobe(VEC[i][19:10]);
      end
      check(tick_no == 8'd2 && slot_no == 2'd0, "R2 tick advance", int'({tick_no, slot_no}), 8);
      for (int i = 0; i < 8; i++) begin
         host_read(VEC[i][9:0], rd);
         check(rd == {6'd0, VEC[i][19:10]}, "R4 stored sample", int'(rd), int'(VEC[i][19:10]));
      end

      // R10: idle cycles leave counters alone and write nothing
      repeat (5) @(negedge clk);
      check(tick_no == 8'd2 && slot_no == 2'd0, "R10 hold", int'({tick_no, slot_no}), 8);
      host_read(10'd8, rd);
      host_write(10'd8, 16'hBEEF);

      // R8: freeze blocks the write but not the counters
      freeze = 1'b1;
      strobe(10'h155);
      freeze = 1'b0;
      check(tick_no == 8'd2 && slot_no == 2'd1, "R8 counters run", int'({tick_no, slot_no}), 9);
      host_read(10'd8, rd);
      check(rd == 16'hBEEF, "R8 frozen word", int'(rd), 16'hBEEF);

      // R5, R6, R7: load, replay, confirm no overwrite
      host_write(10'd9,  16'hA5C3);
      host_write(10'd10, 16'h7E01);
      host_write(10'd11, 16'hFFFF);
      replay_en = 1'b1;
      strobe(10'h000);
      check(play_valid == 1'b1 && play_data == 10'h1C3, "R6 replay word 9", int'(play_data), 10'h1C3);
      @(negedge clk);
      check(play_valid == 1'b0, "R6 valid pulse", int'(play_valid), 0);
      strobe(10'h3FF);
      check(play_valid == 1'b1 && play_data == 10'h201, "R6 replay word 10", int'(play_data), 10'h201);
      strobe(10'h000);
      check(play_valid == 1'b1 && play_data == 10'h3FF, "R6 replay word 11", int'(play_data), 10'h3FF);
      replay_en = 1'b0;
      host_read(10'd9, rd);
      check(rd == 16'hA5C3, "R7 word 9 kept", int'(rd), 16'hA5C3);
      host_read(10'd10, rd);
      check(rd == 16'h7E01, "R7 word 10 kept", int'(rd), 16'h7E01);
      host_read(10'd11, rd);
      check(rd == 16'hFFFF, "R5 R7 word 11 kept", int'(rd), 16'hFFFF);

      // R3: run to the end of the turn
      for (int i = 12; i < 635; i++) strobe(10'(i));
      check(tick_no == 8'd158 && slot_no == 2'd3, "R3 last slot", int'({tick_no, slot_no}), 635);
      strobe(10'h123);
      check(tick_no == 8'd0 && slot_no == 2'd0, "R3 turn wrap", int'({tick_no, slot_no}), 0);

      // R9: clash at word 0, host wins
      @(negedge clk);
      smp_valid = 1'b1; smp_data = 10'h0AA;
      host_we = 1'b1; host_addr = 10'd0; host_wdata = 16'h1234;
      @(negedge clk);
      smp_valid = 1'b0; host_we = 1'b0;
      host_read(10'd0, rd);
      check(rd == 16'h1234, "R9 host wins", int'(rd), 16'h1234);

      // R5: top of the array, full 16-bit words
      host_write(10'd1023, 16'hFFFF);
      host_write(10'd1022, 16'h8001);
      host_read(10'd1023, rd);
      check(rd == 16'hFFFF, "R5 word 1023", int'(rd), 16'hFFFF);
      host_read(10'd1022, rd);
      check(rd == 16'h8001, "R5 word 1022", int'(rd), 16'h8001);

      finish_run();
   end
endmodule